// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block is a real-time clock with a resolution of one tenth of a second. It keeps tenths, seconds, minutes and hours in BCD, using twelve-hour counting with a PM flag. The clock advances on a slow external tick input running at 50 Hz or 60 Hz. The tick is resynchronised to the system clock and divided down, so that every fifth or sixth tick edge adds one tenth of a second.

Software reaches the clock through a byte-wide register port with four addresses. A select input decides whether writes go to the time registers or to a second set of alarm registers at the same addresses. Reads always return the time. Writing the hours register freezes the clock, and it restarts only when the tenths register is written. This lets software set the time piece by piece and then start it at an exact moment. Reading hours takes a snapshot of all four bytes, and the snapshot is kept until tenths is read, so a multi-byte read cannot be torn by a carry. When the running time reaches the alarm setting, the block emits a single-cycle interrupt strobe.

Top module: `rtc_bcd_alarm`

## Requirements
- R1: After reset, the time reads tenths 0x00, seconds 0x00, minutes 0x00 and hours 0x12 (twelve, AM). The clock is stopped and `alarm_irq` is low.
- R2: While running, one tenth is added for every 5 rising edges of `tick_in` when `rate_50` is 1, and for every 6 rising edges when `rate_50` is 0.
- R3: Each BCD stage rolls over as follows: tenths after 9, seconds and minutes after 59. Hours count 12, 1 through 9, 10, 11 and back to 12. The PM flag toggles only on the step from 11:59:59.9 to 12:00:00.0.
- R4: A time write (`alarm_sel`=0) to the hours register stops counting. A time write to tenths restarts it and clears the partial tick count. Tick edges that arrive while stopped are lost.
- R5: A read of hours freezes the values that all four addresses return. They stay frozen until tenths is read, and that tenths read still returns the frozen value. Counting continues underneath, so the next read shows the live time.
- R6: With `alarm_sel`=1, writes go to the alarm registers and leave the time unchanged. Reads return the time whatever the value of `alarm_sel`.
- R7: `alarm_irq` is high for exactly one cycle, in the same cycle in which the time register takes a value equal to the alarm setting.
- R8: Address 0 is tenths, with the value in bits 3:0. Address 1 is seconds, with tens in bits 6:4 and units in bits 3:0. Address 2 is minutes, laid out as seconds. Address 3 is hours, with PM in bit 7, the tens digit in bit 4 and units in bits 3:0. Bits outside these fields are dropped on a write and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register address: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| rd_en | input | 1 | Read strobe; drives the snapshot control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_sel`, combinational |
| rate_50 | input | 1 | 1 selects a 50 Hz tick, 0 selects a 60 Hz tick |
| alarm_sel | input | 1 | 1 sends writes to the alarm registers |
| tick_in | input | 1 | Asynchronous mains-rate tick |
| alarm_irq | output | 1 | One-cycle alarm strobe |

## Verification
A tick edge passes through two synchroniser flops and the registered divider. The time register is updated on the following edge, so the new time appears four clock edges after the tick rises. The checks therefore wait eight cycles after the last tick pulse before reading. `rd_data` is combinational, so each read is sampled a quarter period after the address is set up, before the edge that can change the snapshot state. The alarm strobe lands on the same edge as the matching time update, and the bench counts strobes over the whole tick burst rather than predicting the exact cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam logic [1:0] A_TENTHS = 2'd0;
   localparam logic [1:0] A_SEC    = 2'd1;
   localparam logic [1:0] A_MIN    = 2'd2;
   localparam logic [1:0] A_HOUR   = 2'd3;

   typedef struct packed {
      logic       pm;
      logic       hr_t;
      logic [3:0] hr_u;
      logic [2:0] mn_t;
      logic [3:0] mn_u;
      logic [2:0] sc_t;
      logic [3:0] sc_u;
      logic [3:0] tn;
   } rtc_time_t;

   localparam rtc_time_t TIME_RESET = '{pm: 1'b0, hr_t: 1'b1, hr_u: 4'd2,
                                        mn_t: 3'd0, mn_u: 4'd0, sc_t: 3'd0,
                                        sc_u: 4'd0, tn: 4'd0};

   function automatic logic [7:0] rtc_field(input rtc_time_t t, input logic [1:0] a);
      case (a)
         A_TENTHS: rtc_field = {4'b0, t.tn};
         A_SEC:    rtc_field = {1'b0, t.sc_t, t.sc_u};
         A_MIN:    rtc_field = {1'b0, t.mn_t, t.mn_u};
         default:  rtc_field = {t.pm, 2'b00, t.hr_t, t.hr_u};
      endcase
   endfunction

   function automatic rtc_time_t rtc_write(input rtc_time_t t, input logic [1:0] a,
                                           input logic [7:0] d);
      rtc_time_t n = t;
      case (a)
         A_TENTHS: n.tn = d[3:0];
         A_SEC:    begin n.sc_t = d[6:4]; n.sc_u = d[3:0]; end
         A_MIN:    begin n.mn_t = d[6:4]; n.mn_u = d[3:0]; end
         default:  begin n.pm = d[7]; n.hr_t = d[4]; n.hr_u = d[3:0]; end
      endcase
      return n;
   endfunction
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
   parameter int SYNC_STAGES = 2,
   parameter int DIV_FAST    = 5,
   parameter int DIV_SLOW    = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic fast_i,
   input  logic run_i,
   input  logic clr_i,
   output logic step_o
);
   localparam int CW = $clog2(DIV_SLOW + 1);

   generate
      if (SYNC_STAGES < 2 || DIV_FAST < 1 || DIV_SLOW < DIV_FAST) begin : g_bad_param
         $error("rtc_tick_div: illegal parameter set");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [CW-1:0]          cnt_q;
   logic [CW-1:0]          limit;
   logic                   rise;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else if (i == 0) sync_q[i] <= tick_i;
            else sync_q[i] <= sync_q[(i > 0) ? i - 1 : 0];
         end
      end
   endgenerate

   assign rise  = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign limit = fast_i ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
         step_o <= 1'b0;
      end else begin
         prev_q <= sync_q[SYNC_STAGES-1];
         step_o <= 1'b0;
         if (clr_i || !run_i) begin
            cnt_q <= '0;
         end else if (rise) begin
            if (cnt_q >= limit) begin
               cnt_q  <= '0;
               step_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(DIV_SLOW));
   p_step_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> !step_o);
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
   import rtc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        adv_i,
   input  logic        wr_i,
   input  logic [1:0]  wr_addr_i,
   input  logic [7:0]  wr_data_i,
   output rtc_time_t   now_o,
   output rtc_time_t   next_o
);
   logic [4:0] hr_bcd;
   assign hr_bcd = {now_o.hr_t, now_o.hr_u};

   always_comb begin
      next_o = now_o;
      if (now_o.tn != 4'd9) next_o.tn = now_o.tn + 4'd1;
      else begin
         next_o.tn = 4'd0;
         if (now_o.sc_u != 4'd9) next_o.sc_u = now_o.sc_u + 4'd1;
         else begin
            next_o.sc_u = 4'd0;
            if (now_o.sc_t != 3'd5) next_o.sc_t = now_o.sc_t + 3'd1;
            else begin
               next_o.sc_t = 3'd0;
               if (now_o.mn_u != 4'd9) next_o.mn_u = now_o.mn_u + 4'd1;
               else begin
                  next_o.mn_u = 4'd0;
                  if (now_o.mn_t != 3'd5) next_o.mn_t = now_o.mn_t + 3'd1;
                  else begin
                     next_o.mn_t = 3'd0;
                     if (hr_bcd == 5'h12) begin
                        next_o.hr_t = 1'b0;
                        next_o.hr_u = 4'd1;
                     end else if (now_o.hr_u == 4'd9) begin
                        next_o.hr_t = 1'b1;
                        next_o.hr_u = 4'd0;
                     end else begin
                        next_o.hr_u = now_o.hr_u + 4'd1;
                        if (hr_bcd == 5'h11) next_o.pm = ~now_o.pm;
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     now_o <= TIME_RESET;
      else if (wr_i)  now_o <= rtc_write(now_o, wr_addr_i, wr_data_i);
      else if (adv_i) now_o <= next_o;
   end

   p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !wr_i) |=> $stable(now_o));
   p_pm_only_at_noon_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && $past(!wr_i) && $changed(now_o.pm)) |-> ({now_o.hr_t, now_o.hr_u} == 5'h12));
endmodule

// File: rtl/rtc_read_latch.sv
module rtc_read_latch
   import rtc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd_i,
   input  logic [1:0]  addr_i,
   input  rtc_time_t   live_i,
   output logic [7:0]  data_o
);
   logic      held_q;
   rtc_time_t snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         snap_q <= TIME_RESET;
      end else if (rd_i && !held_q && addr_i == A_HOUR) begin
         held_q <= 1'b1;
         snap_q <= live_i;
      end else if (rd_i && held_q && addr_i == A_TENTHS) begin
         held_q <= 1'b0;
      end
   end

   assign data_o = rtc_field(held_q ? snap_q : live_i, addr_i);

   p_snap_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      held_q |=> $stable(snap_q));
   p_release_on_tenths_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && rd_i && addr_i == A_TENTHS) |=> !held_q);
endmodule

// File: rtl/rtc_bcd_alarm.sv
module rtc_bcd_alarm
   import rtc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DIV_FAST    = 5,
   parameter int DIV_SLOW    = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_sel,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       rate_50,
   input  logic       alarm_sel,
   input  logic       tick_in,
   output logic       alarm_irq
);
   logic      run_q;
   logic      step;
   logic      adv;
   logic      time_wr;
   logic      alarm_wr;
   rtc_time_t now_t;
   rtc_time_t next_t;
   rtc_time_t alarm_q;

   assign time_wr  = wr_en && !alarm_sel;
   assign alarm_wr = wr_en &&  alarm_sel;
   assign adv      = step && run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else if (time_wr && reg_sel == A_HOUR)   run_q <= 1'b0;
      else if (time_wr && reg_sel == A_TENTHS) run_q <= 1'b1;
   end

   rtc_tick_div #(
      .SYNC_STAGES(SYNC_STAGES),
      .DIV_FAST   (DIV_FAST),
      .DIV_SLOW   (DIV_SLOW)
   ) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_i(tick_in),
      .fast_i(rate_50),
      .run_i (run_q),
      .clr_i (time_wr && reg_sel == A_TENTHS),
      .step_o(step)
   );

   rtc_time_chain i_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_i    (adv),
      .wr_i     (time_wr),
      .wr_addr_i(reg_sel),
      .wr_data_i(wr_data),
      .now_o    (now_t),
      .next_o   (next_t)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        alarm_q <= '0;
      else if (alarm_wr) alarm_q <= rtc_write(alarm_q, reg_sel, wr_data);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alarm_irq <= 1'b0;
      else        alarm_irq <= adv && !time_wr && (next_t == alarm_q);
   end

   rtc_read_latch i_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_i  (rd_en),
      .addr_i(reg_sel),
      .live_i(now_t),
      .data_o(rd_data)
   );

   p_irq_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |=> !alarm_irq);
   p_irq_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> (now_t == alarm_q));
   p_alarm_write_keeps_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_wr && !adv) |=> $stable(now_t));
   p_stopped_by_hours_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (time_wr && reg_sel == A_HOUR) |=> !run_q);
endmodule

// File: tb/test_rtc_bcd_alarm.sv
module test_rtc_bcd_alarm;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       rate_50 = 1'b0;
   logic       alarm_sel = 1'b0;
   logic       tick_in = 1'b0;
   logic       alarm_irq;

   int total = 0;
   int bad = 0;
   int irq_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_bcd_alarm i_rtc_bcd_alarm (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .rate_50(rate_50), .alarm_sel(alarm_sel),
      .tick_in(tick_in), .alarm_irq(alarm_irq)
   );

   always @(posedge clk) if (alarm_irq) irq_cnt <= irq_cnt + 1;

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_sel = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_sel = a; rd_en = 1'b1;
      #5 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_in = 1'b1;
         repeat (3) @(negedge clk);
         tick_in = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                           input logic [7:0] s, input logic [7:0] t);
      alarm_sel = 1'b0;
      wr(2'd3, h); wr(2'd2, m); wr(2'd1, s); wr(2'd0, t);
   endtask

   task automatic expect_time(input string req, input logic [7:0] h, input logic [7:0] m,
                              input logic [7:0] s, input logic [7:0] t);
      rd_chk(req, 2'd3, h); rd_chk(req, 2'd2, m);
      rd_chk(req, 2'd1, s); rd_chk(req, 2'd0, t);
   endtask

   task automatic t_reset;
      chk("R1 irq", {7'b0, alarm_irq}, 8'h00);
      expect_time("R1", 8'h12, 8'h00, 8'h00, 8'h00);
      ticks(12);
      rd_chk("R1 stopped", 2'd0, 8'h00);
   endtask

   task automatic t_rollover;
      rate_50 = 1'b0;
      set_time(8'h11, 8'h59, 8'h59, 8'h09);
      ticks(5);
      rd_chk("R2 60Hz five edges", 2'd0, 8'h09);
      ticks(1);
      expect_time("R3 noon", 8'h92, 8'h00, 8'h00, 8'h00);
      set_time(8'h92, 8'h59, 8'h59, 8'h09);
      ticks(6);
      expect_time("R3 twelve to one", 8'h81, 8'h00, 8'h00, 8'h00);
      set_time(8'h09, 8'h59, 8'h59, 8'h09);
      ticks(6);
      expect_time("R3 nine to ten", 8'h10, 8'h00, 8'h00, 8'h00);
   endtask

   task automatic t_stop_start;
      rate_50 = 1'b1;
      set_time(8'h02, 8'h00, 8'h00, 8'h00);
      wr(2'd3, 8'h02);
      ticks(13);
      rd_chk("R4 frozen", 2'd0, 8'h00);
      wr(2'd0, 8'h00);
      ticks(4);
      rd_chk("R4 prescaler cleared", 2'd0, 8'h00);
      ticks(1);
      rd_chk("R2 R4 50Hz restart", 2'd0, 8'h01);
   endtask

   task automatic t_latch;
      rate_50 = 1'b1;
      set_time(8'h03, 8'h04, 8'h05, 8'h06);
      rd_chk("R5 hours read", 2'd3, 8'h03);
      ticks(10);
      rd_chk("R5 seconds held", 2'd1, 8'h05);
      rd_chk("R5 tenths held", 2'd0, 8'h06);
      rd_chk("R5 live after release", 2'd0, 8'h08);
   endtask

   task automatic t_alarm;
      rate_50 = 1'b1;
      alarm_sel = 1'b1;
      wr(2'd3, 8'h01); wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h03);
      set_time(8'h01, 8'h00, 8'h00, 8'h01);
      alarm_sel = 1'b1;
      rd_chk("R6 read returns time", 2'd0, 8'h01);
      wr(2'd0, 8'h03);
      rd_chk("R6 alarm write no effect", 2'd0, 8'h01);
      alarm_sel = 1'b0;
      @(negedge clk);
      irq_cnt = 0;
      ticks(20);
      chk("R7 one strobe", 8'(irq_cnt), 8'd1);
      rd_chk("R7 time moved on", 2'd0, 8'h05);
   endtask

   task automatic t_unused;
      alarm_sel = 1'b0;
      wr(2'd3, 8'hFF); wr(2'd2, 8'hFF); wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
      expect_time("R8 masks", 8'h9F, 8'h7F, 8'h7F, 8'h0F);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_rollover();
      t_stop_start();
      t_latch();
      t_alarm();
      t_unused();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule